// File: doc/BRIEF.md
# Accumulator Saturation and Overflow Status Unit

This block sits at the write-back end of a multiply-accumulate datapath. It takes a wide two's complement working value holding a freshly computed accumulator sum and clamps it to the range allowed by the selected mode: signed 40-bit, unsigned 40-bit, signed 32-bit, or a guarded signed 32-bit mode. The guarded mode picks its clamp value from the sign the accumulator had before the operation. A mixed-mode flag makes the signed modes treat only the low 32 bits as significant, sign-extending them before the clamp.

For each accumulator there are two status bits. The overflow bit is rewritten by every operation on that accumulator. The sticky overflow bit is only ever set by a saturating operation, and only an external clear input lowers it. The clamped value and the saturation flag are registered and appear one cycle after the input strobe. The status bits update on the same clock edge.

Top module: `acc_sat_unit`

## Requirements
- R1: Mode 2'b00 (signed 40-bit) clamps the working value to the range [-2^39, 2^39-1]. A value above the range gives 40'h7FFFFFFFFF, a value below it gives 40'h8000000000, and either case raises the saturation flag.
- R2: With the mixed flag set in modes 2'b00, 2'b10 and 2'b11, the working value is first replaced by the sign extension of its bits 31..0. In mode 2'b01 the mixed flag has no effect.
- R3: When no clamp happens in mode 2'b00, the output is bits 39..0 of the working value and the saturation flag is low.
- R4: Mode 2'b01 (unsigned 40-bit) treats a negative working value (bit 63 set) as overflow and gives 0. A value above 40'hFFFFFFFFFF gives 40'hFFFFFFFFFF. Both cases raise the saturation flag.
- R5: Mode 2'b10 (signed 32-bit) clamps to [-2^31, 2^31-1] and sign-extends bit 31 of the kept value into bits 39..32. The limits are 40'h007FFFFFFF and 40'hFF80000000.
- R6: In mode 2'b11, bits 63..31 that are neither all ones nor all zeros give 40'hFF80000000 when the prior-sign input is 1, and 40'h007FFFFFFF when it is 0, with saturation flagged. Otherwise the output is bits 31..0 sign-extended, with no saturation.
- R7: Each valid operation writes its saturation flag into the overflow bit of the addressed accumulator. A saturating operation also sets that accumulator's sticky bit. Bits of other accumulators are unchanged.
- R8: A sticky bit falls only when its clear input bit is high. If a saturating operation sets the same sticky bit in the same cycle, the set wins.
- R9: The output valid, clamped value and saturation flag appear exactly one cycle after the input strobe. Back-to-back strobes give back-to-back results.
- R10: After reset the output valid, the clamped value, the saturation flag and all overflow and sticky bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_sum | input | 64 | Wide two's complement working value |
| in_mode | input | 2 | Clamp mode: 00 s40, 01 u40, 10 s32, 11 guarded s32 |
| in_mixed | input | 1 | Mixed-mode flag (low-32-bit sign extension) |
| in_idx | input | 1 | Accumulator index |
| in_prev_neg | input | 1 | Sign bit 39 of the accumulator before the operation |
| sticky_clr | input | 2 | Per-accumulator sticky overflow clear |
| out_valid | output | 1 | Result valid |
| out_acc | output | 40 | Clamped accumulator value |
| out_sat | output | 1 | Saturation occurred |
| ovf | output | 2 | Per-accumulator overflow bit |
| ovf_sticky | output | 2 | Per-accumulator sticky overflow bit |

## Verification
The case that needs care is a saturating write to an accumulator in the same cycle that the clear for that accumulator's sticky bit is raised. The bench drives a saturating value with the matching clear bit set in the same strobe. It then expects the sticky bit to stay high, which shows that the set took precedence. A following clear with no operation must lower it. The scoreboard records the expected overflow and sticky vectors with each queued result, so a wrong order of clear and set shows up when that result is compared.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  typedef enum logic [1:0] {
    CLAMP_S40 = 2'b00,
    CLAMP_U40 = 2'b01,
    CLAMP_S32 = 2'b10,
    CLAMP_G32 = 2'b11
  } clamp_mode_e;
endpackage

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp
  import acc_sat_pkg::*;
#(
  parameter int WORK_W   = 64,
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32
) (
  input  logic [WORK_W-1:0] sum,
  input  logic [1:0]        mode,
  input  logic              mixed,
  input  logic              prev_neg,
  output logic [ACC_W-1:0]  res,
  output logic              sat
);
  localparam int EXT_N = ACC_W - NARROW_W;
  localparam logic [ACC_W-1:0] WIDE_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] WIDE_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] NAR_MAX  = {{(EXT_N+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NAR_MIN  = {{(EXT_N+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  clamp_mode_e        cm;
  logic [WORK_W-1:0]  v;
  logic               neg;
  logic               wide_hi, wide_lo, uns_hi, nar_uniform;
  logic [ACC_W-1:0]   nar_ext;

  assign cm = clamp_mode_e'(mode);

  always_comb begin
    if (mixed && cm != CLAMP_U40)
      v = {{(WORK_W-NARROW_W){sum[NARROW_W-1]}}, sum[NARROW_W-1:0]};
    else
      v = sum;
  end

  assign neg         = v[WORK_W-1];
  assign wide_hi     = !neg && (|v[WORK_W-2:ACC_W-1]);
  assign wide_lo     = neg && !(&v[WORK_W-2:ACC_W-1]);
  assign uns_hi      = |v[WORK_W-2:ACC_W];
  assign nar_uniform = (&v[WORK_W-1:NARROW_W-1]) || !(|v[WORK_W-1:NARROW_W-1]);
  assign nar_ext     = {{EXT_N{v[NARROW_W-1]}}, v[NARROW_W-1:0]};

  always_comb begin
    res = v[ACC_W-1:0];
    sat = 1'b0;
    unique case (cm)
      CLAMP_S40: begin
        if (wide_hi) begin
          res = WIDE_MAX; sat = 1'b1;
        end else if (wide_lo) begin
          res = WIDE_MIN; sat = 1'b1;
        end
      end
      CLAMP_U40: begin
        if (neg) begin
          res = '0; sat = 1'b1;
        end else if (uns_hi) begin
          res = '1; sat = 1'b1;
        end
      end
      CLAMP_S32: begin
        res = nar_ext;
        if (!nar_uniform) begin
          res = neg ? NAR_MIN : NAR_MAX;
          sat = 1'b1;
        end
      end
      default: begin
        res = nar_ext;
        if (!nar_uniform) begin
          res = prev_neg ? NAR_MIN : NAR_MAX;
          sat = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/acc_sat_flags.sv
module acc_sat_flags #(
  parameter int NUM_ACC = 2,
  parameter int IDX_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [IDX_W-1:0]   idx,
  input  logic               sat,
  input  logic [NUM_ACC-1:0] clr,
  output logic [NUM_ACC-1:0] ovf,
  output logic [NUM_ACC-1:0] sticky
);
  for (genvar a = 0; a < NUM_ACC; a++) begin : g_acc
    logic hit;
    assign hit = upd && (idx == IDX_W'(a));

    always_ff @(posedge clk) begin
      if (rst) begin
        ovf[a]    <= 1'b0;
        sticky[a] <= 1'b0;
      end else begin
        if (hit)
          ovf[a] <= sat;
        if (hit && sat)
          sticky[a] <= 1'b1;
        else if (clr[a])
          sticky[a] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit #(
  parameter int WORK_W   = 64,
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32,
  parameter int NUM_ACC  = 2,
  parameter int IDX_W    = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WORK_W-1:0]  in_sum,
  input  logic [1:0]         in_mode,
  input  logic               in_mixed,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic               in_prev_neg,
  input  logic [NUM_ACC-1:0] sticky_clr,
  output logic               out_valid,
  output logic [ACC_W-1:0]   out_acc,
  output logic               out_sat,
  output logic [NUM_ACC-1:0] ovf,
  output logic [NUM_ACC-1:0] ovf_sticky
);
  logic [ACC_W-1:0] clamp_res;
  logic             clamp_sat;

  acc_sat_clamp #(
    .WORK_W(WORK_W), .ACC_W(ACC_W), .NARROW_W(NARROW_W)
  ) u_clamp (
    .sum(in_sum), .mode(in_mode), .mixed(in_mixed),
    .prev_neg(in_prev_neg), .res(clamp_res), .sat(clamp_sat)
  );

  acc_sat_flags #(
    .NUM_ACC(NUM_ACC), .IDX_W(IDX_W)
  ) u_flags (
    .clk(clk), .rst(rst), .upd(in_valid), .idx(in_idx),
    .sat(clamp_sat), .clr(sticky_clr), .ovf(ovf), .sticky(ovf_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_acc <= clamp_res;
        out_sat <= clamp_sat;
      end
    end
  end
endmodule

// File: rtl/acc_sat_unit_chk.sv
module acc_sat_unit_chk #(
  parameter int WORK_W   = 64,
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32,
  parameter int NUM_ACC  = 2,
  parameter int IDX_W    = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [WORK_W-1:0]  in_sum,
  input logic [1:0]         in_mode,
  input logic               in_mixed,
  input logic [IDX_W-1:0]   in_idx,
  input logic               in_prev_neg,
  input logic [NUM_ACC-1:0] sticky_clr,
  input logic               out_valid,
  input logic [ACC_W-1:0]   out_acc,
  input logic               out_sat,
  input logic [NUM_ACC-1:0] ovf,
  input logic [NUM_ACC-1:0] ovf_sticky
);
  // R9
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sat && $past(in_mode) == 2'b00 && !$past(in_mixed))
    |-> ($past(in_sum) == {{(WORK_W-ACC_W){out_acc[ACC_W-1]}}, out_acc}));

  // R5
  p_narrow_ext_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == 2'b10)
    |-> ((&out_acc[ACC_W-1:NARROW_W-1]) || !(|out_acc[ACC_W-1:NARROW_W-1])));

  // R6
  p_guard_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat && $past(in_mode) == 2'b11)
    |-> (out_acc[ACC_W-1] == $past(in_prev_neg)));

  // R7
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat) |-> (ovf[$past(in_idx)] && ovf_sticky[$past(in_idx)]));

  // R8
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ovf_sticky) & ~$past(sticky_clr) & ~ovf_sticky) == '0));
endmodule

bind acc_sat_unit acc_sat_unit_chk #(
  .WORK_W(WORK_W), .ACC_W(ACC_W), .NARROW_W(NARROW_W),
  .NUM_ACC(NUM_ACC), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sum(in_sum),
  .in_mode(in_mode), .in_mixed(in_mixed), .in_idx(in_idx),
  .in_prev_neg(in_prev_neg), .sticky_clr(sticky_clr),
  .out_valid(out_valid), .out_acc(out_acc), .out_sat(out_sat),
  .ovf(ovf), .ovf_sticky(ovf_sticky)
);

// File: tb/acc_sat_unit_test.sv
`timescale 1ns/1ps
module acc_sat_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_sum = '0;
  logic [1:0]  in_mode = '0;
  logic        in_mixed = 1'b0;
  logic        in_idx = 1'b0;
  logic        in_prev_neg = 1'b0;
  logic [1:0]  sticky_clr = '0;
  logic        out_valid;
  logic [39:0] out_acc;
  logic        out_sat;
  logic [1:0]  ovf, ovf_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_sat_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sum(in_sum),
    .in_mode(in_mode), .in_mixed(in_mixed), .in_idx(in_idx),
    .in_prev_neg(in_prev_neg), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .out_acc(out_acc), .out_sat(out_sat),
    .ovf(ovf), .ovf_sticky(ovf_sticky)
  );

  typedef struct {
    logic [39:0] acc;
    logic        sat;
    logic [1:0]  ovf;
    logic [1:0]  sticky;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [1:0]  m_ovf = '0;
  logic [1:0]  m_sticky = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] s_in, input logic [1:0] mode,
                                input bit mixed, input bit pneg,
                                output logic [39:0] r, output logic sat);
    longint s;
    s = longint'(s_in);
    if (mixed && mode != 2'b01) s = longint'(int'(s_in[31:0]));
    sat = 1'b0;
    case (mode)
      2'b00: begin
        if (s > 64'sh7F_FFFF_FFFF)         begin r = 40'h7FFFFFFFFF; sat = 1; end
        else if (s < -64'sh80_0000_0000)   begin r = 40'h8000000000; sat = 1; end
        else r = s[39:0];
      end
      2'b01: begin
        if (s < 0)                         begin r = 40'h0; sat = 1; end
        else if (s > 64'shFF_FFFF_FFFF)    begin r = 40'hFFFFFFFFFF; sat = 1; end
        else r = s[39:0];
      end
      2'b10: begin
        if (s > 64'sh7FFF_FFFF)            begin r = 40'h007FFFFFFF; sat = 1; end
        else if (s < -64'sh8000_0000)      begin r = 40'hFF80000000; sat = 1; end
        else r = {{8{s[31]}}, s[31:0]};
      end
      default: begin
        if (s > 64'sh7FFF_FFFF || s < -64'sh8000_0000) begin
          r = pneg ? 40'hFF80000000 : 40'h007FFFFFFF; sat = 1;
        end else r = {{8{s[31]}}, s[31:0]};
      end
    endcase
  endfunction

  task automatic op(input logic [63:0] s, input logic [1:0] mode, input bit mixed,
                    input bit idx, input bit pneg, input logic [1:0] clr,
                    input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_sum = s; in_mode = mode; in_mixed = mixed;
    in_idx = idx; in_prev_neg = pneg; sticky_clr = clr;
    model(s, mode, mixed, pneg, e.acc, e.sat);
    m_sticky = m_sticky & ~clr;
    m_ovf[idx] = e.sat;
    if (e.sat) m_sticky[idx] = 1'b1;
    e.ovf = m_ovf; e.sticky = m_sticky; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [1:0] clr);
    @(negedge clk);
    in_valid = 1'b0; sticky_clr = clr;
    m_sticky = m_sticky & ~clr;
  endtask

  task automatic drain();
    idle(2'b00);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the oldest expectation when a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected result", 64'(out_acc), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_acc === e.acc, e.req, "acc", 64'(out_acc), 64'(e.acc));
        check(out_sat === e.sat, e.req, "sat", 64'(out_sat), 64'(e.sat));
        check(ovf === e.ovf, "R7", "ovf", 64'(ovf), 64'(e.ovf));
        check(ovf_sticky === e.sticky, "R8", "sticky", 64'(ovf_sticky), 64'(e.sticky));
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check({out_valid, out_sat, out_acc, ovf, ovf_sticky} === '0, "R10", "reset",
          64'({out_valid, out_sat, out_acc, ovf, ovf_sticky}), 64'h0);
    @(negedge clk); rst = 1'b0;

    // R1 / R3 signed 40-bit
    op(64'h0000_0100_0000_0000, 2'b00, 0, 0, 0, 2'b00, "R1");
    op(64'hFFFF_FF00_0000_0000 - 64'd1, 2'b00, 0, 0, 0, 2'b00, "R1");
    op(64'h0000_007F_FFFF_FFFF, 2'b00, 0, 0, 0, 2'b00, "R3");
    op(64'hFFFF_FF80_0000_0000, 2'b00, 0, 0, 0, 2'b00, "R3");
    op(64'h0000_0000_1234_5678, 2'b00, 0, 1, 0, 2'b00, "R3");
    // R2 mixed: signed extends, unsigned ignores
    op(64'h0000_0055_8000_0000, 2'b00, 1, 0, 0, 2'b00, "R2");
    op(64'h0000_0000_8000_0000, 2'b01, 1, 0, 0, 2'b00, "R2");
    op(64'h0000_0001_8000_0000, 2'b10, 1, 1, 0, 2'b00, "R2");
    // R4 unsigned
    op(64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 0, 1, 0, 2'b00, "R4");
    op(64'h0000_0100_0000_0000, 2'b01, 0, 0, 0, 2'b00, "R4");
    op(64'h0000_00FF_FFFF_FFFF, 2'b01, 0, 0, 0, 2'b00, "R4");
    // R5 signed 32-bit
    op(64'h0000_0000_8000_0000, 2'b10, 0, 0, 0, 2'b00, "R5");
    op(64'h0000_0000_7FFF_FFFF, 2'b10, 0, 0, 0, 2'b00, "R5");
    op(64'hFFFF_FFFF_7FFF_FFFF, 2'b10, 0, 1, 0, 2'b00, "R5");
    op(64'hFFFF_FFFF_8000_0000, 2'b10, 0, 1, 0, 2'b00, "R5");
    // R6 guarded
    op(64'h0000_0001_0000_0000, 2'b11, 0, 0, 1, 2'b00, "R6");
    op(64'h0000_0001_0000_0000, 2'b11, 0, 0, 0, 2'b00, "R6");
    op(64'hFFFF_FFFF_FFFF_FFF0, 2'b11, 0, 0, 1, 2'b00, "R6");
    drain();

    // R8 clear alone, then clear together with a saturating set
    idle(2'b11);
    @(negedge clk);
    check(ovf_sticky === 2'b00, "R8", "clear", 64'(ovf_sticky), 64'h0);
    op(64'h0000_0100_0000_0000, 2'b00, 0, 0, 0, 2'b01, "R8");
    drain();
    check(ovf_sticky[0] === 1'b1, "R8", "set wins over clear", 64'(ovf_sticky[0]), 64'h1);
    op(64'h0, 2'b00, 0, 0, 0, 2'b00, "R7");
    drain();
    check(ovf_sticky[0] === 1'b1 && ovf[0] === 1'b0, "R7", "ovf cleared sticky held",
          64'({ovf, ovf_sticky}), 64'h1);
    idle(2'b01);
    @(negedge clk);
    check(ovf_sticky[0] === 1'b0, "R8", "clear after set", 64'(ovf_sticky), 64'h0);

    // R9 back-to-back mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [63:0] s;
      logic [1:0]  m;
      s = {$urandom, $urandom};
      case (i % 4)
        0: s = {{24{s[63]}}, s[39:0]};
        1: s = {{32{s[63]}}, s[31:0]};
        default: ;
      endcase
      m = 2'($urandom);
      op(s, m, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), "R9");
    end
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule